// File: doc/BRIEF.md
# Dual Comparator Change-Detect Interrupt

This block conditions the digital results of two analog comparators and turns any change in them into a sticky interrupt flag. Each raw result is first brought into the clock domain by a synchronizer, then optionally inverted per channel, and forced to 0 when the mode field switches that channel off. Software sees the two conditioned outputs, the two invert controls and the mode field through one control/status register.

Change is not judged against the previous clock sample. It is judged against a reference snapshot that is taken whenever software reads or writes the control/status register. While the live outputs differ from that snapshot, the flag is set again on every clock, so software must read the register before a flag clear can take effect. Software can also set the flag itself. An interrupt request leaves the block only when three enable levels are all on. A separate wake request covers the low-power state.

Top module: `cmp_chg_irq`

## Requirements
- R1: Each conditioned output equals its synchronized raw input XOR its invert bit. Read data bit 6 carries channel 0 and bit 7 carries channel 1. A raw change appears there after the second rising clock edge.
- R2: Read data bits 5:4 return the invert bits (bit 4 is channel 0), bit 3 reads 0, and bits 2:0 return the mode field. A register write loads the invert bits and the mode field from the same bit positions.
- R3: Mode 3'b111 switches both channels off and holds both outputs at 0. Mode 3'b110 enables channel 0 only and holds channel 1 at 0. Every other mode enables both channels.
- R4: When a conditioned output differs from its reference, the flag is 1 after the next rising edge, which is the third edge after the raw change.
- R5: A register read loads the current conditioned outputs into the reference. A register write loads the conditioned outputs that result from the written values. Neither access sets the flag.
- R6: While a mismatch remains, the flag is set on every edge, and a flag write of 0 leaves it at 1.
- R7: With no mismatch, a flag write of 0 clears the flag and a flag write of 1 sets it.
- R8: If a mismatch exists in the cycle in which a register read is sampled, the read takes priority. The reference captures the new outputs and the flag is not set.
- R9: irq_o is 1 only when the flag, the peripheral enable, the group enable and the global enable are all 1. The flag sets regardless of the enables.
- R10: wake_o is 1 when sleep_i, the flag and the peripheral enable are all 1. Sleep leaves the register contents unchanged.
- R11: After reset the mode field is 3'b111, the invert bits are 0, the reference is 0 and the flag is 0, so read data is 8'h07.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| raw_cmp_i | input | 2 | Raw comparator results (bit 0 = channel 0) |
| reg_rd_i | input | 1 | Control/status register read strobe |
| reg_wr_i | input | 1 | Control/status register write strobe |
| reg_wdata_i | input | 8 | Control/status write data |
| flag_wr_i | input | 1 | Interrupt flag write strobe |
| flag_wdata_i | input | 1 | Value written to the flag |
| per_en_i | input | 1 | Peripheral-level interrupt enable |
| grp_en_i | input | 1 | Peripheral-group interrupt enable |
| glb_en_i | input | 1 | Global interrupt enable |
| sleep_i | input | 1 | Device is in low-power state |
| reg_rdata_o | output | 8 | Control/status read data |
| flag_o | output | 1 | Sticky interrupt flag |
| irq_o | output | 1 | Gated interrupt request |
| wake_o | output | 1 | Wake request |

## Verification
The properties assume that a register access, a flag write and the enables are held stable for one full clock cycle. They also assume that no access arrives during the two cycles in which the internal reset is still being released. The stimulus drives every strobe for exactly one cycle from the falling edge. It starts accesses only after a settling delay that follows the reset release. Raw comparator changes are placed a whole number of cycles apart, so each synchronizer edge can be predicted.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  localparam int NCH    = 2;
  localparam int MODE_W = 3;
  localparam logic [MODE_W-1:0] MODE_ALL_OFF  = 3'b111;
  localparam logic [MODE_W-1:0] MODE_CH0_ONLY = 3'b110;

  typedef struct packed {
    logic [NCH-1:0]    inv;
    logic [MODE_W-1:0] mode;
  } cmp_ctrl_t;

  function automatic logic [NCH-1:0] chan_enable(input logic [MODE_W-1:0] mode);
    logic [NCH-1:0] en;
    for (int i = 0; i < NCH; i++) begin
      en[i] = (mode != MODE_ALL_OFF) && !((mode == MODE_CH0_ONLY) && (i != 0));
    end
    return en;
  endfunction
endpackage

// File: rtl/cmp_rst_sync.sv
module cmp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] stage_d;
      if (s == 0) begin : g_first
        always_comb stage_d = d_i;
      end else begin : g_next
        always_comb stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/cmp_chan.sv
module cmp_chan (
  input  logic sync_i,
  input  logic inv_i,
  input  logic en_i,
  output logic out_o
);
  always_comb begin
    out_o = en_i ? (sync_i ^ inv_i) : 1'b0;
  end
endmodule

// File: rtl/cmp_flag_ctl.sv
module cmp_flag_ctl #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] live_i,
  input  logic [N-1:0] post_wr_i,
  input  logic         rd_i,
  input  logic         wr_i,
  input  logic         flag_wr_i,
  input  logic         flag_wdata_i,
  output logic         flag_o
);
  logic [N-1:0] ref_q, ref_d;
  logic         ref_en;
  logic         flag_q, flag_d;
  logic         mismatch;

  always_comb begin
    ref_en = rd_i | wr_i;
    ref_d  = wr_i ? post_wr_i : live_i;
    // an access in this cycle wins over the compare
    mismatch = (live_i != ref_q) && !ref_en;
    flag_d = flag_q;
    if (flag_wr_i) flag_d = flag_wdata_i;
    if (mismatch)  flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ref_q <= '0;
    else if (ref_en) ref_q <= ref_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/cmp_chg_irq.sv
module cmp_chg_irq
  import cmp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] raw_cmp_i,
  input  logic       reg_rd_i,
  input  logic       reg_wr_i,
  input  logic [7:0] reg_wdata_i,
  input  logic       flag_wr_i,
  input  logic       flag_wdata_i,
  input  logic       per_en_i,
  input  logic       grp_en_i,
  input  logic       glb_en_i,
  input  logic       sleep_i,
  output logic [7:0] reg_rdata_o,
  output logic       flag_o,
  output logic       irq_o,
  output logic       wake_o
);
  logic           rst_int_n;
  logic [NCH-1:0] sync_cmp;
  cmp_ctrl_t      ctrl_q, ctrl_d, ctrl_wr;
  logic [NCH-1:0] en_live, en_wr;
  logic [NCH-1:0] cond_live, cond_wr;
  logic           flag;

  cmp_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  cmp_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .d_i(raw_cmp_i), .q_o(sync_cmp)
  );

  always_comb begin
    ctrl_wr.inv  = reg_wdata_i[5:4];
    ctrl_wr.mode = reg_wdata_i[2:0];
    ctrl_d       = reg_wr_i ? ctrl_wr : ctrl_q;
    en_live      = chan_enable(ctrl_q.mode);
    en_wr        = chan_enable(ctrl_wr.mode);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ctrl_q.inv  <= '0;
      ctrl_q.mode <= MODE_ALL_OFF;
    end else if (reg_wr_i) begin
      ctrl_q <= ctrl_d;
    end
  end

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_chan
      cmp_chan u_live (
        .sync_i(sync_cmp[c]), .inv_i(ctrl_q.inv[c]), .en_i(en_live[c]), .out_o(cond_live[c])
      );
      cmp_chan u_wr (
        .sync_i(sync_cmp[c]), .inv_i(ctrl_wr.inv[c]), .en_i(en_wr[c]), .out_o(cond_wr[c])
      );
    end
  endgenerate

  cmp_flag_ctl #(.N(NCH)) u_flag (
    .clk(clk), .rst_n(rst_int_n),
    .live_i(cond_live), .post_wr_i(cond_wr),
    .rd_i(reg_rd_i), .wr_i(reg_wr_i),
    .flag_wr_i(flag_wr_i), .flag_wdata_i(flag_wdata_i),
    .flag_o(flag)
  );

  always_comb begin
    reg_rdata_o = {cond_live, ctrl_q.inv, 1'b0, ctrl_q.mode};
    flag_o      = flag;
    irq_o       = flag & per_en_i & grp_en_i & glb_en_i;
    wake_o      = sleep_i & flag & per_en_i;
  end
endmodule

// File: rtl/cmp_chg_irq_chk.sv
module cmp_chg_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_rd_i,
  input logic       reg_wr_i,
  input logic       flag_wr_i,
  input logic       flag_wdata_i,
  input logic       per_en_i,
  input logic       grp_en_i,
  input logic       glb_en_i,
  input logic       sleep_i,
  input logic [7:0] reg_rdata_o,
  input logic       flag_o,
  input logic       irq_o,
  input logic       wake_o
);
  assert_off_mode_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata_o[2:0] == 3'b111) |-> (reg_rdata_o[7:6] == 2'b00));

  assert_bit3_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata_o[3] == 1'b0);

  assert_read_no_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_i && !flag_wr_i && !flag_o) |=> !flag_o);

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !flag_wr_i) |=> flag_o);

  assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr_i && flag_wdata_i) |=> flag_o);

  assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr_i && !flag_wdata_i && reg_rd_i) |=> !flag_o);

  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_o || !glb_en_i || !grp_en_i || !per_en_i) |-> !irq_o);

  assert_wake_sleep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (sleep_i && flag_o));
endmodule

bind cmp_chg_irq cmp_chg_irq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .reg_rd_i(reg_rd_i), .reg_wr_i(reg_wr_i),
  .flag_wr_i(flag_wr_i), .flag_wdata_i(flag_wdata_i), .per_en_i(per_en_i),
  .grp_en_i(grp_en_i), .glb_en_i(glb_en_i), .sleep_i(sleep_i),
  .reg_rdata_o(reg_rdata_o), .flag_o(flag_o), .irq_o(irq_o), .wake_o(wake_o)
);

// File: tb/cmp_chg_irq_tb_top.sv
module cmp_chg_irq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] raw_cmp_i = '0;
  logic       reg_rd_i = 1'b0, reg_wr_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic       flag_wr_i = 1'b0, flag_wdata_i = 1'b0;
  logic       per_en_i = 1'b0, grp_en_i = 1'b0, glb_en_i = 1'b0, sleep_i = 1'b0;
  logic [7:0] reg_rdata_o;
  logic       flag_o, irq_o, wake_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cmp_chg_irq dut_i (.*);

  // {mode[2:0], inv[1:0], raw[1:0], expected outputs[1:0]}
  localparam int NV = 8;
  localparam logic [8:0] VEC [NV] = '{
    {3'b000, 2'b00, 2'b10, 2'b10},
    {3'b000, 2'b11, 2'b10, 2'b01},
    {3'b001, 2'b01, 2'b00, 2'b01},
    {3'b111, 2'b11, 2'b11, 2'b00},
    {3'b110, 2'b00, 2'b11, 2'b01},
    {3'b110, 2'b10, 2'b00, 2'b00},
    {3'b010, 2'b10, 2'b01, 2'b11},
    {3'b101, 2'b00, 2'b01, 2'b01}
  };

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] d);
    reg_wr_i = 1'b1; reg_wdata_i = d; tick(); reg_wr_i = 1'b0;
  endtask

  task automatic do_read();
    reg_rd_i = 1'b1; tick(); reg_rd_i = 1'b0;
  endtask

  task automatic do_flag(input logic v);
    flag_wr_i = 1'b1; flag_wdata_i = v; tick(); flag_wr_i = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tick(2); rst_n = 1'b1; tick(4);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R11 reset state
    check("R11 rdata", reg_rdata_o, 8'h07);
    check("R11 flag", {7'b0, flag_o}, 8'h00);
    check("R11 irq", {7'b0, irq_o}, 8'h00);

    // R1 R2 R3 vector walk
    for (int v = 0; v < NV; v++) begin
      raw_cmp_i = VEC[v][3:2];
      do_write({2'b00, VEC[v][5:4], 1'b0, VEC[v][8:6]});
      tick(3);
      do_read();
      do_flag(1'b0);
      check("R1 R3 outputs", {6'b0, reg_rdata_o[7:6]}, {6'b0, VEC[v][1:0]});
      check("R2 fields", {2'b0, reg_rdata_o[5:0]}, {2'b0, VEC[v][5:4], 1'b0, VEC[v][8:6]});
      check("R7 flag cleared", {7'b0, flag_o}, 8'h00);
    end

    // settle: both channels on, no inversion, raw 01
    raw_cmp_i = 2'b01;
    do_write(8'h00);
    tick(3); do_read(); do_flag(1'b0);
    check("R5 settled flag", {7'b0, flag_o}, 8'h00);

    // R4 timing
    raw_cmp_i = 2'b11;
    tick(2);
    check("R1 visible after two edges", {6'b0, reg_rdata_o[7:6]}, 8'h03);
    check("R4 flag not yet", {7'b0, flag_o}, 8'h00);
    tick();
    check("R4 flag set", {7'b0, flag_o}, 8'h01);

    // R6 clear fails while mismatch persists
    do_flag(1'b0);
    check("R6 clear ignored", {7'b0, flag_o}, 8'h01);
    tick(2);
    check("R6 still set", {7'b0, flag_o}, 8'h01);
    do_read(); do_flag(1'b0);
    check("R5 read then clear", {7'b0, flag_o}, 8'h00);

    // R5 write loads post-write outputs
    do_write(8'h20);
    tick(3);
    check("R5 write no flag", {7'b0, flag_o}, 8'h00);
    check("R5 write outputs", {6'b0, reg_rdata_o[7:6]}, 8'h01);

    // R8 change coincident with read
    raw_cmp_i = 2'b01;
    tick(2);
    do_read();
    tick(2);
    check("R8 flag missed", {7'b0, flag_o}, 8'h00);
    check("R8 capture", {6'b0, reg_rdata_o[7:6]}, 8'h03);

    // R9 enable chain
    per_en_i = 1'b1; grp_en_i = 1'b1; glb_en_i = 1'b1;
    check("R9 no flag no irq", {7'b0, irq_o}, 8'h00);
    glb_en_i = 1'b0;
    do_flag(1'b1);
    check("R7 soft set", {7'b0, flag_o}, 8'h01);
    check("R9 global off", {7'b0, irq_o}, 8'h00);
    glb_en_i = 1'b1; tick();
    check("R9 all on", {7'b0, irq_o}, 8'h01);

    // R10 wake
    sleep_i = 1'b1; tick();
    check("R10 wake", {7'b0, wake_o}, 8'h01);
    per_en_i = 1'b0; tick();
    check("R10 wake gated", {7'b0, wake_o}, 8'h00);
    check("R10 contents kept", reg_rdata_o, 8'hE0);
    sleep_i = 1'b0; per_en_i = 1'b1;
    do_flag(1'b0);
    check("R7 soft clear", {7'b0, flag_o}, 8'h00);

    // R11 reset mid-run
    do_reset();
    check("R11 rdata again", reg_rdata_o, 8'h07);
    check("R11 flag again", {7'b0, flag_o}, 8'h00);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule